// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Lock Detect

This block compares two pulse streams for each of two synthesizer sections: a reference stream and a feedback stream coming back from the divided oscillator. All inputs are sampled on one system clock, and a rising edge on either stream is what the block compares. Each section produces a three-state pump command: source, sink or off. It can also produce a balanced pulse in which source and sink are both on. Each section also has a polarity bit and a power-save input.

A lock tracker in each section measures how long the pump has been driving one way before the other edge arrives. It declares lock only after several close comparisons in a row, and it drops lock as soon as one comparison runs long. The two lock flags combine into one registered status pin, and a section that is powered down counts as locked. The same pin can instead show any one of the four raw input streams, for probing a board.

After reset, and again when a section leaves power save, the first one-sided pump drive is capped. This keeps the loop from taking a large frequency step after it wakes. The balanced reset pulse width, the lock window limits, the count of good comparisons needed for lock and the wake cap are all parameters.

Top module: `pfd_dual_lock`

## Requirements
- R1: With `fc_pos` high, a reference edge seen before the feedback edge drives `pump_src` (and not `pump_snk`) from the cycle after the edge. A feedback edge seen first drives `pump_snk`. With no pending edge, both outputs are 0.
- R2: With `fc_pos` low, the roles of `pump_src` and `pump_snk` in R1 are exchanged.
- R3: When both edges are pending, `pump_src` and `pump_snk` are both 1 for exactly RST_DLY cycles (default 2). After that both are 0, so a zero phase error still gives a short pulse.
- R4: A further edge on the stream that is already pending is ignored. The pending drive continues, and no extra drive follows the end of the comparison.
- R5: A section's lock rises after LOCK_N (default 3) consecutive comparisons whose one-sided width is at most TWL cycles (default 2). It does not rise earlier.
- R6: A section's lock falls in the cycle in which its one-sided drive has lasted TWU cycles (default 4), without waiting for the other edge. It also falls at any comparison of width TWU or more.
- R7: A comparison with a width above TWL and below TWU restarts the good-comparison count and leaves the lock flag unchanged.
- R8: While `pwr_on` of a section is 0, both of its pump outputs are 0, its detector and lock flag clear, and it counts as locked in the combined status.
- R9: With `mon_en` 0, `ld_mon` is registered (one cycle) as the AND over both sections of (locked OR powered down).
- R10: With `mon_en` 1, `ld_mon` is registered (one cycle) from a raw input. `mon_sel[0]` picks the section (0 low band, 1 high band) and `mon_sel[1]` picks the stream (0 reference, 1 feedback).
- R11: After reset or after leaving power save, the first comparison's one-sided drive is shown for at most WAKE_CAP cycles (default 8). Later comparisons are not capped.
- R12: During reset, all pump outputs and `ld_mon` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | Reference pulse stream per section (bit 0 low band, bit 1 high band) |
| fb_in | input | 2 | Feedback pulse stream per section |
| pwr_on | input | 2 | 1 = section active, 0 = power save |
| fc_pos | input | 2 | Pump polarity per section |
| mon_en | input | 1 | 0 = lock status on `ld_mon`, 1 = raw monitor |
| mon_sel | input | 2 | Monitor select: bit 0 section, bit 1 stream |
| pump_src | output | 2 | Pump drives high, per section |
| pump_snk | output | 2 | Pump drives low, per section |
| ld_mon | output | 1 | Registered lock status or monitor signal |

## Verification
The bench aims at the edges of the lock window. It runs a comparison exactly at TWL, one between the limits, and one that runs past TWU before the feedback edge arrives. A tracker that counted non-consecutive good comparisons would lock too early, and one that waited for the edge would keep lock too long. The bench also pushes a second reference edge while one is pending, which a careless detector would turn into an extra pump pulse. It checks the capped first pulse after wake and the uncapped second one; wrong bookkeeping of the wake state would cap every comparison or none. Finally it drops a section into power save in the middle of a pulse, to catch a pump that stays driving or a combined status that ignores the power state.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    localparam int NSEC = 2;

    typedef enum logic [1:0] {
        PUMP_OFF  = 2'b00,
        PUMP_SINK = 2'b01,
        PUMP_SRC  = 2'b10,
        PUMP_BAL  = 2'b11
    } pump_e;

    typedef struct packed {
        logic up;      // reference edge pending
        logic dn;      // feedback edge pending
        logic cmp;     // first cycle with both pending
        logic single;  // exactly one pending
        logic capped;  // wake cap reached
    } pfd_flags_t;

    function automatic pump_e pump_code(input logic on, input logic fc,
                                        input pfd_flags_t f);
        pump_e code;
        if (!on)
            code = PUMP_OFF;
        else if (f.up && f.dn)
            code = PUMP_BAL;
        else if (f.capped)
            code = PUMP_OFF;
        else if (f.up)
            code = fc ? PUMP_SRC : PUMP_SINK;
        else if (f.dn)
            code = fc ? PUMP_SINK : PUMP_SRC;
        else
            code = PUMP_OFF;
        return code;
    endfunction

    function automatic logic mon_pick(input logic [NSEC-1:0] r,
                                      input logic [NSEC-1:0] f,
                                      input logic [1:0] sel);
        return sel[1] ? f[sel[0]] : r[sel[0]];
    endfunction

endpackage

// File: rtl/pfd_phase_core.sv
`timescale 1ns/1ps
module pfd_phase_core
    import pfd_pkg::*;
#(
    parameter int RST_DLY  = 2,
    parameter int WAKE_CAP = 8,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_in,
    input  logic          fb_in,
    input  logic          pwr_on,
    output pfd_flags_t    flags,
    output logic [CW-1:0] width
);
    localparam int RCW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
    localparam logic [RCW-1:0] RC_LAST = RCW'(RST_DLY - 1);
    localparam logic [CW-1:0]  CAP_W   = CW'(WAKE_CAP);

    logic           ref_q, fb_q;
    logic           up_q, dn_q, first_q;
    logic [RCW-1:0] rc_q;
    logic [CW-1:0]  w_q;
    logic           ref_edge, fb_edge;

    assign ref_edge = ref_in & ~ref_q;
    assign fb_edge  = fb_in & ~fb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= 1'b0;
            fb_q    <= 1'b0;
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            first_q <= 1'b1;
            rc_q    <= '0;
            w_q     <= '0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
            if (!pwr_on) begin
                up_q    <= 1'b0;
                dn_q    <= 1'b0;
                first_q <= 1'b1;
                rc_q    <= '0;
                w_q     <= '0;
            end else if (up_q && dn_q) begin
                if (rc_q == '0)
                    first_q <= 1'b0;
                if (rc_q == RC_LAST) begin
                    up_q <= 1'b0;
                    dn_q <= 1'b0;
                    rc_q <= '0;
                    w_q  <= '0;
                end else begin
                    rc_q <= rc_q + RCW'(1);
                end
            end else begin
                if (up_q ^ dn_q)
                    w_q <= (w_q == '1) ? w_q : w_q + CW'(1);
                if (ref_edge)
                    up_q <= 1'b1;
                if (fb_edge)
                    dn_q <= 1'b1;
            end
        end
    end

    assign flags.up     = up_q;
    assign flags.dn     = dn_q;
    assign flags.cmp    = pwr_on & up_q & dn_q & (rc_q == '0);
    assign flags.single = up_q ^ dn_q;
    assign flags.capped = first_q & (w_q >= CAP_W);
    assign width        = w_q;

endmodule

// File: rtl/pfd_lock_track.sv
`timescale 1ns/1ps
module pfd_lock_track #(
    parameter int TWU    = 4,
    parameter int TWL    = 2,
    parameter int LOCK_N = 3,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_on,
    input  logic          cmp,
    input  logic          single,
    input  logic [CW-1:0] width,
    output logic          locked
);
    localparam int GW = $clog2(LOCK_N + 1);

    logic [GW-1:0] good_q;
    logic          lock_q;
    logic          long_now;

    assign long_now = single && (int'(width) + 1 >= TWU);

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (long_now) begin
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (cmp) begin
            if (int'(width) >= TWU) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end else if (int'(width) <= TWL) begin
                if (int'(good_q) < LOCK_N)
                    good_q <= good_q + GW'(1);
                if (int'(good_q) + 1 >= LOCK_N)
                    lock_q <= 1'b1;
            end else begin
                good_q <= '0;
            end
        end
    end

    assign locked = lock_q;

endmodule

// File: rtl/pfd_pump_map.sv
`timescale 1ns/1ps
module pfd_pump_map
    import pfd_pkg::*;
(
    input  logic       pwr_on,
    input  logic       fc_pos,
    input  pfd_flags_t flags,
    output logic       src,
    output logic       snk
);
    pump_e code;

    always_comb begin
        code = pump_code(pwr_on, fc_pos, flags);
        src  = code[1];
        snk  = code[0];
    end

endmodule

// File: rtl/pfd_dual_lock.sv
`timescale 1ns/1ps
module pfd_dual_lock
    import pfd_pkg::*;
#(
    parameter int RST_DLY  = 2,
    parameter int TWU      = 4,
    parameter int TWL      = 2,
    parameter int LOCK_N   = 3,
    parameter int WAKE_CAP = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ref_in,
    input  logic [1:0] fb_in,
    input  logic [1:0] pwr_on,
    input  logic [1:0] fc_pos,
    input  logic       mon_en,
    input  logic [1:0] mon_sel,
    output logic [1:0] pump_src,
    output logic [1:0] pump_snk,
    output logic       ld_mon
);
    localparam int CMAX = (TWU > WAKE_CAP) ? TWU : WAKE_CAP;
    localparam int CW   = $clog2(CMAX + 2);

    pfd_flags_t        flags [NSEC];
    logic [CW-1:0]     width [NSEC];
    logic [NSEC-1:0]   locked;
    logic              pin_q;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        pfd_phase_core #(
            .RST_DLY (RST_DLY),
            .WAKE_CAP(WAKE_CAP),
            .CW      (CW)
        ) u_core (
            .clk   (clk),
            .rst   (rst),
            .ref_in(ref_in[s]),
            .fb_in (fb_in[s]),
            .pwr_on(pwr_on[s]),
            .flags (flags[s]),
            .width (width[s])
        );

        pfd_lock_track #(
            .TWU   (TWU),
            .TWL   (TWL),
            .LOCK_N(LOCK_N),
            .CW    (CW)
        ) u_lock (
            .clk   (clk),
            .rst   (rst),
            .pwr_on(pwr_on[s]),
            .cmp   (flags[s].cmp),
            .single(flags[s].single),
            .width (width[s]),
            .locked(locked[s])
        );

        pfd_pump_map u_pump (
            .pwr_on(pwr_on[s]),
            .fc_pos(fc_pos[s]),
            .flags (flags[s]),
            .src   (pump_src[s]),
            .snk   (pump_snk[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b0;
        else if (mon_en)
            pin_q <= mon_pick(ref_in, fb_in, mon_sel);
        else
            pin_q <= &(locked | ~pwr_on);
    end

    assign ld_mon = pin_q;

endmodule

// File: rtl/pfd_dual_lock_chk.sv
`timescale 1ns/1ps
module pfd_dual_lock_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ref_in,
    input logic [1:0] fb_in,
    input logic [1:0] pwr_on,
    input logic [1:0] fc_pos,
    input logic       mon_en,
    input logic [1:0] mon_sel,
    input logic [1:0] pump_src,
    input logic [1:0] pump_snk,
    input logic       ld_mon
);
    for (genvar s = 0; s < 2; s++) begin : g_chk
        AST_PS_HIGHZ: assert property (@(posedge clk) disable iff (rst)
            !pwr_on[s] |-> (!pump_src[s] && !pump_snk[s])); // R8

        AST_SRC_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            (fc_pos[s] && $stable(fc_pos[s]) && pwr_on[s] && $past(pwr_on[s])
             && $rose(pump_src[s]) && !pump_snk[s]) |-> $past(ref_in[s])); // R1
    end

    AST_MON_REF_LO: assert property (@(posedge clk) disable iff (rst)
        (mon_en && mon_sel == 2'b00) |=> (ld_mon == $past(ref_in[0]))); // R10

    AST_MON_FB_LO: assert property (@(posedge clk) disable iff (rst)
        (mon_en && mon_sel == 2'b10) |=> (ld_mon == $past(fb_in[0]))); // R10

    AST_MON_FB_HI: assert property (@(posedge clk) disable iff (rst)
        (mon_en && mon_sel == 2'b11) |=> (ld_mon == $past(fb_in[1]))); // R10

    AST_LD_ALL_SAVE: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && pwr_on == 2'b00) |=> ld_mon); // R9

endmodule

bind pfd_dual_lock pfd_dual_lock_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ref_in  (ref_in),
    .fb_in   (fb_in),
    .pwr_on  (pwr_on),
    .fc_pos  (fc_pos),
    .mon_en  (mon_en),
    .mon_sel (mon_sel),
    .pump_src(pump_src),
    .pump_snk(pump_snk),
    .ld_mon  (ld_mon)
);

// File: tb/pfd_dual_lock_bench.sv
`timescale 1ns/1ps
module pfd_dual_lock_bench;
    localparam int RST_DLY  = 2;
    localparam int TWU      = 4;
    localparam int TWL      = 2;
    localparam int LOCK_N   = 3;
    localparam int WAKE_CAP = 8;
    localparam int WMAX     = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_in = '0, fb_in = '0, pwr_on = 2'b11, fc_pos = 2'b11;
    logic       mon_en = 1'b0;
    logic [1:0] mon_sel = '0;
    logic [1:0] pump_src, pump_snk;
    logic       ld_mon;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pfd_dual_lock #(
        .RST_DLY(RST_DLY), .TWU(TWU), .TWL(TWL),
        .LOCK_N(LOCK_N), .WAKE_CAP(WAKE_CAP)
    ) u_pfd_dual_lock (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .pwr_on(pwr_on), .fc_pos(fc_pos), .mon_en(mon_en),
        .mon_sel(mon_sel), .pump_src(pump_src), .pump_snk(pump_snk),
        .ld_mon(ld_mon)
    );

    // behavioural reference model
    int m_up[2], m_dn[2], m_rc[2], m_w[2], m_good[2], m_lock[2], m_first[2];
    int m_pr[2], m_pf[2];
    bit m_pin;

    always @(posedge clk) begin
        if (rst) begin
            m_pin = 0;
            for (int s = 0; s < 2; s++) begin
                m_up[s] = 0; m_dn[s] = 0; m_rc[s] = 0; m_w[s] = 0;
                m_good[s] = 0; m_lock[s] = 0; m_first[s] = 1;
                m_pr[s] = 0; m_pf[s] = 0;
            end
        end else begin
            if (mon_en)
                m_pin = mon_sel[1] ? fb_in[mon_sel[0]] : ref_in[mon_sel[0]];
            else
                m_pin = (m_lock[0] != 0 || !pwr_on[0]) && (m_lock[1] != 0 || !pwr_on[1]);
            for (int s = 0; s < 2; s++) begin
                bit er, ef, one, two;
                er = ref_in[s] && m_pr[s] == 0;
                ef = fb_in[s] && m_pf[s] == 0;
                m_pr[s] = ref_in[s];
                m_pf[s] = fb_in[s];
                if (!pwr_on[s]) begin
                    m_up[s] = 0; m_dn[s] = 0; m_rc[s] = 0; m_w[s] = 0;
                    m_good[s] = 0; m_lock[s] = 0; m_first[s] = 1;
                end else begin
                    one = m_up[s] != m_dn[s];
                    two = m_up[s] != 0 && m_dn[s] != 0;
                    if (one && m_w[s] + 1 >= TWU) begin
                        m_lock[s] = 0; m_good[s] = 0;
                    end else if (two && m_rc[s] == 0) begin
                        if (m_w[s] >= TWU) begin
                            m_lock[s] = 0; m_good[s] = 0;
                        end else if (m_w[s] <= TWL) begin
                            if (m_good[s] < LOCK_N) m_good[s]++;
                            if (m_good[s] >= LOCK_N) m_lock[s] = 1;
                        end else begin
                            m_good[s] = 0;
                        end
                    end
                    if (two) begin
                        if (m_rc[s] == 0) m_first[s] = 0;
                        if (m_rc[s] == RST_DLY - 1) begin
                            m_up[s] = 0; m_dn[s] = 0; m_rc[s] = 0; m_w[s] = 0;
                        end else m_rc[s]++;
                    end else begin
                        if (one && m_w[s] < WMAX) m_w[s]++;
                        if (er) m_up[s] = 1;
                        if (ef) m_dn[s] = 1;
                    end
                end
            end
        end
    end

    function automatic bit exp_drive(int s, bit want_src);
        bit both, sup, lead, lag;
        if (!pwr_on[s]) return 0;
        both = m_up[s] != 0 && m_dn[s] != 0;
        sup  = m_first[s] != 0 && m_w[s] >= WAKE_CAP;
        lead = m_up[s] != 0 && m_dn[s] == 0 && !sup;
        lag  = m_dn[s] != 0 && m_up[s] == 0 && !sup;
        if (both) return 1;
        if (want_src) return fc_pos[s] ? lead : lag;
        return fc_pos[s] ? lag : lead;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            for (int s = 0; s < 2; s++) begin
                chk($sformatf("R1/R2/R3/R4/R8/R11 pump_src[%0d]", s), pump_src[s], exp_drive(s, 1));
                chk($sformatf("R1/R2/R3/R4/R8/R11 pump_snk[%0d]", s), pump_snk[s], exp_drive(s, 0));
            end
            chk("R5/R6/R7/R9/R10 ld_mon", ld_mon, m_pin);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pair(int s, int d);
        int g;
        bit lead;
        g = (d < 0) ? -d : d;
        @(negedge clk);
        if (d >= 0) ref_in[s] = 1;
        if (d <= 0) fb_in[s] = 1;
        @(negedge clk);
        if (d == 0) begin
            chk("R3 balanced src", pump_src[s], 1);
            chk("R3 balanced snk", pump_snk[s], 1);
        end else begin
            lead = d > 0;
            chk(fc_pos[s] ? "R1 src" : "R2 src", pump_src[s], fc_pos[s] ? lead : !lead);
            chk(fc_pos[s] ? "R1 snk" : "R2 snk", pump_snk[s], fc_pos[s] ? !lead : lead);
        end
        ref_in[s] = 0;
        fb_in[s] = 0;
        if (d != 0) begin
            idle(g - 1);
            if (d > 0) fb_in[s] = 1; else ref_in[s] = 1;
            @(negedge clk);
            ref_in[s] = 0;
            fb_in[s] = 0;
        end else begin
            idle(2);
            chk("R3 off after pulse src", pump_src[s], 0);
            chk("R3 off after pulse snk", pump_snk[s], 0);
        end
        idle(4);
    endtask

    initial begin
        idle(3);
        chk("R12 reset src", pump_src, 0);
        chk("R12 reset snk", pump_snk, 0);
        chk("R12 reset pin", ld_mon, 0);
        rst = 0;
        pwr_on = 2'b01;
        idle(2);

        // polarity and balanced pulse: R1 R2 R3
        pair(0, 3);
        pair(0, -2);
        fc_pos[0] = 0;
        pair(0, 3);
        pair(0, -2);
        pair(0, 0);
        fc_pos[0] = 1;

        // repeated lead edge: R4
        @(negedge clk); ref_in[0] = 1;
        @(negedge clk); ref_in[0] = 0;
        idle(2); ref_in[0] = 1;
        @(negedge clk); ref_in[0] = 0;
        chk("R4 pending src", pump_src[0], 1);
        fb_in[0] = 1;
        @(negedge clk); fb_in[0] = 0;
        idle(3);
        chk("R4 no extra src", pump_src[0], 0);
        chk("R4 no extra snk", pump_snk[0], 0);
        idle(3);

        // lock entry: R5
        pair(0, 1);
        pair(0, -1);
        chk("R5 not yet locked", ld_mon, 0);
        pair(0, 1);
        chk("R5 locked", ld_mon, 1);

        // early unlock during long drive: R6
        @(negedge clk); ref_in[0] = 1;
        @(negedge clk); ref_in[0] = 0;
        idle(6);
        chk("R6 unlock before feedback", ld_mon, 0);
        fb_in[0] = 1;
        @(negedge clk); fb_in[0] = 0;
        idle(4);

        // neutral width restarts count: R7
        pair(0, 1);
        pair(0, 1);
        pair(0, 3);
        pair(0, 1);
        pair(0, 1);
        chk("R7 count restarted", ld_mon, 0);
        pair(0, 1);
        chk("R7 locked after restart", ld_mon, 1);

        // combined status: R9
        pwr_on = 2'b11;
        idle(2);
        chk("R9 one unlocked", ld_mon, 0);
        pair(1, 1);
        pair(1, -1);
        pair(1, 1);
        chk("R9 both locked", ld_mon, 1);

        // power save mid-pulse: R8
        @(negedge clk); ref_in[0] = 1;
        @(negedge clk); ref_in[0] = 0;
        chk("R8 drive before save", pump_src[0], 1);
        @(negedge clk); pwr_on[0] = 0;
        #1;
        chk("R8 save src off", pump_src[0], 0);
        chk("R8 save snk off", pump_snk[0], 0);
        @(negedge clk);
        chk("R8 saved counts locked", ld_mon, 1);
        fb_in[0] = 1;
        @(negedge clk); fb_in[0] = 0;
        @(negedge clk); pwr_on[0] = 1;
        idle(2);
        chk("R8 lock cleared by save", ld_mon, 0);
        pwr_on = 2'b00;
        idle(2);
        chk("R9 both saved", ld_mon, 1);
        pwr_on = 2'b11;
        idle(2);

        // wake cap: R11
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ref_in[0] = 1;
            @(negedge clk); ref_in[0] = 0;
            idle(2);
            chk("R11 early drive", pump_src[0], 1);
            idle(7);
            chk(k == 0 ? "R11 first capped" : "R11 second uncapped", pump_src[0], k == 0 ? 0 : 1);
            idle(2);
            fb_in[0] = 1;
            @(negedge clk); fb_in[0] = 0;
            idle(4);
        end

        // monitor mux: R10
        pwr_on = 2'b00;
        mon_en = 1;
        for (int sel = 0; sel < 4; sel++) begin
            for (int pat = 0; pat < 16; pat++) begin
                bit e;
                @(negedge clk);
                mon_sel = sel[1:0];
                ref_in = pat[1:0];
                fb_in = pat[3:2];
                @(negedge clk);
                e = sel[1] ? pat[2 + sel[0]] : pat[sel[0]];
                chk($sformatf("R10 sel=%0d pat=%0d", sel, pat), ld_mon, e);
            end
        end
        ref_in = 0;
        fb_in = 0;
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule